// File: doc/BRIEF.md
# Aging Priority Arbiter for a Shared Memory Channel

This block decides, once per clock, which of several clients may use a shared memory channel next. Each client raises a request line and holds it while it wants the channel. Every pending request carries a score made of two parts. One is a static priority set by software for that client, multiplied by a global weight. The other is an age that counts how long the request has waited. The pending request with the highest score receives a one-hot grant on the following clock. A waiting request keeps gaining age, so a low-priority client always wins in the end.

A programmable deadline places a hard bound on the wait. When any pending request has an age at or above the deadline, score no longer matters: the oldest of those late requests wins. Equal keys are settled by a rotating order that starts just after the client granted last. Software changes the priorities, the weight and the deadline through a simple write port. A write does not disturb ages that are already counting. No data moves through the block, so its pins are plain control lines and there is no valid/ready handshake and no back-pressure.

Top module: `age_prio_arb`

## Requirements
- R1: While reset (active-low, asynchronous) is asserted and afterwards until a request arrives, the grant output is all zero. Reset sets every age to 0, every priority to 0, the weight to 1 and the deadline to 255. After reset the rotation begins at client 0.
- R2: The grant is registered and one-hot. For the request vector sampled at a rising edge, the grant is visible after that edge. It names only a client that was requesting, it is non-zero whenever any client requested, and it is zero when no client requested.
- R3: When no pending request is past its deadline, the pending client with the largest score priority×weight + age wins.
- R4: A client's age goes up by one on each edge at which that client is requesting and is not granted. The age saturates at 255. It returns to 0 when the client is granted or when its request is low.
- R5: When one or more pending clients have an age greater than or equal to the deadline, the grant goes to the oldest of them, whatever the scores are.
- R6: Among candidates with equal keys, the winner is the first one found when the search starts at the client after the last granted client and wraps upward by client index.
- R7: A write with cfg_we high at a rising edge updates one register. Address k with k < NUM_CLI sets client k's priority from data bits [3:0]. Address NUM_CLI sets the weight from data bits [7:0]. Address NUM_CLI+1 sets the deadline from data bits [7:0]. The new value is used from the arbitration at the next edge. No age is changed by the write.
- R8: A write to any address above NUM_CLI+1 (6 or 7 with the default of 4 clients) changes no register, and so has no effect on any later grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | NUM_CLI | Request line per client, held high while waiting |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | ADDR_W | Configuration register select |
| cfg_wdata | input | DATA_W | Configuration write data |
| gnt | output | NUM_CLI | Registered one-hot grant |

## Verification
Requests from several clients at once with all priorities equal check the rotating tie order against score order. Unequal priorities, then a zero weight, separate the static term from the age term. Two long held requests, one pushed up to its deadline and another pair of equal-age clients pushed up to saturation, tell the deadline override, the choice of the oldest late request and saturation apart from wrap-around. A long random phase with random configuration writes, including writes to unused addresses, checks that writes take effect on the next edge and leave running ages alone.

// File: rtl/arb_pkg.sv
package arb_pkg;

  // Position of the k-th candidate in the rotating search order
  function automatic int rot_slot(input int last, input int k, input int n);
    return (last + 1 + k) % n;
  endfunction

  // Width that holds the sum of a product term and an age term
  function automatic int sum_width(input int prod_w, input int age_w);
    return ((prod_w > age_w) ? prod_w : age_w) + 1;
  endfunction

endpackage

// File: rtl/arb_cfg_regs.sv
module arb_cfg_regs #(
  parameter int NUM_CLI = 4,
  parameter int PRIO_W  = 4,
  parameter int WGT_W   = 8,
  parameter int AGE_W   = 8,
  parameter int ADDR_W  = 3,
  parameter int DATA_W  = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      we,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [DATA_W-1:0]         wdata,
  output logic [NUM_CLI*PRIO_W-1:0] prio_flat,
  output logic [WGT_W-1:0]          weight,
  output logic [AGE_W-1:0]          deadline
);
  localparam logic [ADDR_W-1:0] WGT_ADDR = ADDR_W'(NUM_CLI);
  localparam logic [ADDR_W-1:0] DL_ADDR  = ADDR_W'(NUM_CLI + 1);

  for (genvar g = 0; g < NUM_CLI; g++) begin : g_prio
    logic [PRIO_W-1:0] prio_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        prio_q <= '0;
      else if (we && addr == ADDR_W'(g))
        prio_q <= wdata[PRIO_W-1:0];
    end
    assign prio_flat[g*PRIO_W +: PRIO_W] = prio_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      weight   <= WGT_W'(1);
      deadline <= '1;
    end else if (we) begin
      if (addr == WGT_ADDR) weight <= wdata[WGT_W-1:0];
      if (addr == DL_ADDR)  deadline <= wdata[AGE_W-1:0];
    end
  end

  // R8
  ignored_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr > DL_ADDR) |=> ($stable(weight) && $stable(deadline) && $stable(prio_flat)));

endmodule

// File: rtl/arb_age_ctr.sv
module arb_age_ctr #(
  parameter int AGE_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pending,
  input  logic             won,
  output logic [AGE_W-1:0] age
);
  localparam logic [AGE_W-1:0] AGE_MAX = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      age <= '0;
    else if (!pending || won)
      age <= '0;
    else if (age != AGE_MAX)
      age <= age + AGE_W'(1);
  end

  // R4
  age_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && !won && age == AGE_MAX) |=> (age == AGE_MAX));
  // R4
  age_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    won |=> (age == '0));
  // R4
  age_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && !won && age != AGE_MAX) |=> (age == $past(age) + AGE_W'(1)));

endmodule

// File: rtl/arb_score.sv
module arb_score #(
  parameter int PRIO_W  = 4,
  parameter int WGT_W   = 8,
  parameter int AGE_W   = 8,
  parameter int SCORE_W = 13
) (
  input  logic [PRIO_W-1:0]  prio,
  input  logic [WGT_W-1:0]   weight,
  input  logic [AGE_W-1:0]   age,
  input  logic [AGE_W-1:0]   deadline,
  output logic               late,
  output logic [SCORE_W:0]   key
);
  logic [SCORE_W-1:0] product;
  logic [SCORE_W-1:0] total;

  always_comb begin
    product = SCORE_W'(prio) * SCORE_W'(weight);
    total   = product + SCORE_W'(age);
    late    = (age >= deadline);
    // A late request ranks above every on-time one; late ones rank by age
    key     = late ? {1'b1, SCORE_W'(age)} : {1'b0, total};
  end

endmodule

// File: rtl/arb_rot_pick.sv
module arb_rot_pick
  import arb_pkg::*;
#(
  parameter int NUM_CLI = 4,
  parameter int KEY_W   = 14,
  parameter int IDX_W   = 2
) (
  input  logic [NUM_CLI-1:0]       cand,
  input  logic [NUM_CLI*KEY_W-1:0] keys,
  input  logic [IDX_W-1:0]         last,
  output logic                     found,
  output logic [IDX_W-1:0]         win_idx
);
  logic [KEY_W-1:0] best_key;
  logic [KEY_W-1:0] this_key;
  int               slot;

  always_comb begin
    found    = 1'b0;
    win_idx  = '0;
    best_key = '0;
    this_key = '0;
    slot     = 0;
    for (int k = 0; k < NUM_CLI; k++) begin
      slot     = rot_slot(int'(last), k, NUM_CLI);
      this_key = keys[slot*KEY_W +: KEY_W];
      if (cand[slot] && (!found || this_key > best_key)) begin
        found    = 1'b1;
        best_key = this_key;
        win_idx  = IDX_W'(slot);
      end
    end
  end

endmodule

// File: rtl/age_prio_arb.sv
module age_prio_arb
  import arb_pkg::*;
#(
  parameter int NUM_CLI = 4,
  parameter int PRIO_W  = 4,
  parameter int WGT_W   = 8,
  parameter int AGE_W   = 8,
  parameter int DATA_W  = 8,
  parameter int ADDR_W  = $clog2(NUM_CLI + 2)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_CLI-1:0] req,
  input  logic               cfg_we,
  input  logic [ADDR_W-1:0]  cfg_addr,
  input  logic [DATA_W-1:0]  cfg_wdata,
  output logic [NUM_CLI-1:0] gnt
);
  localparam int SCORE_W = sum_width(PRIO_W + WGT_W, AGE_W);
  localparam int KEY_W   = SCORE_W + 1;
  localparam int IDX_W   = (NUM_CLI > 1) ? $clog2(NUM_CLI) : 1;

  logic [NUM_CLI*PRIO_W-1:0] prio_flat;
  logic [WGT_W-1:0]          weight;
  logic [AGE_W-1:0]          deadline;
  logic [NUM_CLI*AGE_W-1:0]  age_flat;
  logic [NUM_CLI*KEY_W-1:0]  key_flat;
  logic [NUM_CLI-1:0]        late_vec;
  logic [NUM_CLI-1:0]        won_vec;
  logic                      found;
  logic [IDX_W-1:0]          win_idx;
  logic [IDX_W-1:0]          last_q;

  arb_cfg_regs #(
    .NUM_CLI(NUM_CLI), .PRIO_W(PRIO_W), .WGT_W(WGT_W),
    .AGE_W(AGE_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .prio_flat(prio_flat), .weight(weight), .deadline(deadline)
  );

  for (genvar g = 0; g < NUM_CLI; g++) begin : g_cli
    arb_age_ctr #(.AGE_W(AGE_W)) u_age (
      .clk(clk), .rst_n(rst_n), .pending(req[g]), .won(won_vec[g]),
      .age(age_flat[g*AGE_W +: AGE_W])
    );
    arb_score #(
      .PRIO_W(PRIO_W), .WGT_W(WGT_W), .AGE_W(AGE_W), .SCORE_W(SCORE_W)
    ) u_score (
      .prio(prio_flat[g*PRIO_W +: PRIO_W]), .weight(weight),
      .age(age_flat[g*AGE_W +: AGE_W]), .deadline(deadline),
      .late(late_vec[g]), .key(key_flat[g*KEY_W +: KEY_W])
    );
    assign won_vec[g] = found && (win_idx == IDX_W'(g));
  end

  arb_rot_pick #(.NUM_CLI(NUM_CLI), .KEY_W(KEY_W), .IDX_W(IDX_W)) u_pick (
    .cand(req), .keys(key_flat), .last(last_q), .found(found), .win_idx(win_idx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gnt    <= '0;
      last_q <= IDX_W'(NUM_CLI - 1);
    end else begin
      gnt <= won_vec;
      if (found) last_q <= win_idx;
    end
  end

  // R2
  gnt_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));
  // R2
  gnt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req == '0) |=> (gnt == '0));
  // R2
  gnt_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req != '0) |=> (gnt != '0));
  // R2
  gnt_to_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req != '0) |=> ((gnt & ~$past(req)) == '0));
  // R5
  late_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((req & late_vec) != '0) |=> ((gnt & $past(req & late_vec)) != '0));

endmodule

// File: tb/age_prio_arb_test.sv
module age_prio_arb_test;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 4;
  localparam int AW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  req = '0;
  logic          cfg_we = 1'b0;
  logic [AW-1:0] cfg_addr = '0;
  logic [7:0]    cfg_wdata = '0;
  logic [N-1:0]  gnt;

  int checks = 0;
  int fails = 0;
  string phase = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  age_prio_arb uut (
    .clk(clk), .rst_n(rst_n), .req(req), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .gnt(gnt)
  );

  // Behavioural reference model
  int m_age [N];
  int m_prio [N];
  int m_wgt, m_dl, m_last;
  logic [N-1:0] m_gnt;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin m_age[i] = 0; m_prio[i] = 0; end
      m_wgt = 1; m_dl = 255; m_last = N - 1; m_gnt = '0;
    end else begin
      int best, best_key, key, idx;
      best = -1; best_key = -1;
      for (int k = 0; k < N; k++) begin
        idx = (m_last + 1 + k) % N;
        if (req[idx]) begin
          if (m_age[idx] >= m_dl) key = 100000 + m_age[idx];
          else key = m_prio[idx] * m_wgt + m_age[idx];
          if (key > best_key) begin best_key = key; best = idx; end
        end
      end
      for (int i = 0; i < N; i++) begin
        if (!req[i] || i == best) m_age[i] = 0;
        else if (m_age[i] < 255) m_age[i] = m_age[i] + 1;
      end
      m_gnt = '0;
      if (best >= 0) begin m_gnt[best] = 1'b1; m_last = best; end
      if (cfg_we) begin
        if (int'(cfg_addr) < N) m_prio[cfg_addr] = int'(cfg_wdata[3:0]);
        else if (int'(cfg_addr) == N) m_wgt = int'(cfg_wdata);
        else if (int'(cfg_addr) == N + 1) m_dl = int'(cfg_wdata);
      end
    end
  end

  // Compare against the model on every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      checks++;
      if (gnt !== m_gnt) begin
        fails++;
        $display("FAIL %s model compare: gnt=%b expected %b at %0t", phase, gnt, m_gnt, $time);
      end
    end
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    checks++; fails++;
    $display("FAIL watchdog: run hung, actual running expected finished");
    finish_run();
  end

  task automatic step();
    @(negedge clk);
  endtask

  task automatic expect_gnt(input string tag, input logic [N-1:0] exp);
    checks++;
    if (gnt !== exp) begin
      fails++;
      $display("FAIL %s directed: gnt=%b expected %b at %0t", tag, gnt, exp, $time);
    end
  endtask

  task automatic cfg_write(input int a, input int d);
    cfg_we = 1'b1; cfg_addr = AW'(a); cfg_wdata = 8'(d);
    step();
    cfg_we = 1'b0;
  endtask

  initial begin
    // R1 reset state
    step(); step();
    expect_gnt("R1", '0);
    rst_n = 1'b1;
    step();
    expect_gnt("R1", '0);

    // R6 tie order from reset, then rotation
    phase = "R6";
    req = 4'b1111;
    step(); expect_gnt("R6", 4'b0001);
    step(); expect_gnt("R6", 4'b0010);
    req = '0; step(); step();

    // R2 single request, then idle
    phase = "R2";
    req = 4'b0100;
    step(); req = '0; expect_gnt("R2", 4'b0100);
    step(); expect_gnt("R2", 4'b0000);

    // R3 with priorities via R7 writes
    phase = "R3";
    cfg_write(1, 5);
    cfg_write(3, 2);
    req = 4'b1010;
    step(); req = '0; expect_gnt("R3", 4'b0010);
    step();

    // R8 unused addresses leave every register untouched
    phase = "R8";
    cfg_write(6, 8'hff);
    cfg_write(7, 0);
    req = 4'b1010;
    step(); req = '0; expect_gnt("R8", 4'b0010);
    step();

    // R7 weight zero removes the priority term: tie, rotation after 1
    phase = "R7";
    cfg_write(4, 0);
    req = 4'b1010;
    step(); req = '0; expect_gnt("R7", 4'b1000);
    step();
    cfg_write(4, 1);

    // R5 deadline forces a low-score request through
    phase = "R5";
    cfg_write(0, 15);
    cfg_write(4, 20);
    cfg_write(5, 3);
    req = 4'b0011;
    step(); expect_gnt("R5", 4'b0001);
    step(); expect_gnt("R5", 4'b0001);
    step(); expect_gnt("R5", 4'b0001);
    step(); expect_gnt("R5", 4'b0010);
    req = '0; step(); step();

    // R4 saturation: two equal-age waiters reach the limit together
    phase = "R4";
    cfg_write(5, 255);
    req = 4'b1101;
    for (int c = 0; c < 255; c++) begin
      step(); expect_gnt("R4", 4'b0001);
    end
    step(); expect_gnt("R4", 4'b0100);
    step(); expect_gnt("R4", 4'b1000);
    req = '0; step(); step();

    // R7 random writes during live waits; R3 R5 R6 random traffic
    phase = "R7 R3 R5 R6";
    cfg_write(5, 20);
    for (int c = 0; c < 4000; c++) begin
      req = N'($urandom);
      if ($urandom_range(0, 9) == 0) begin
        cfg_we = 1'b1;
        cfg_addr = AW'($urandom);
        cfg_wdata = (cfg_addr == AW'(5)) ? 8'($urandom_range(4, 40))
                                         : 8'($urandom_range(0, 20));
      end else begin
        cfg_we = 1'b0;
      end
      step();
    end
    cfg_we = 1'b0;
    req = '0;
    step(); step();
    finish_run();
  end

endmodule